// File: doc/BRIEF.md
# Multiplexed ADC Scan Controller

This controller sits beside a delta-sigma converter whose serial port works as a slave, and it runs a repeating scan over the inputs of an external analog multiplexer. For each channel it sets the multiplexer select and pulls the active-low convert line down. It then waits for the converter's active-low ready line, lowers chip select, and produces the serial clock to read one 24-bit result. The result leaves the block as a word of the output width, tagged with its channel number and marked by a one-cycle valid strobe.

The converter waits a fixed internal delay after convert falls before it starts sampling. The controller uses that delay as multiplexer settling time: with a lead count of zero, the select changes on the same clock edge on which convert falls. When a buffer amplifier settles too slowly for that, a nonzero lead count moves the select change that many clocks ahead of the convert fall. Convert goes back high once each read is over, so the converter cannot start a new conversion by itself before the select has moved on. A mode input decides how the raw word is widened: sign-extended when the converter runs in bipolar (two's complement) coding, zero-extended for unipolar (straight binary) coding.

Top module: `adc_scan_ctrl`

## Requirements
- R1: When reset is high, and in the first cycle after it, conv_n and cs_n are 1, sclk is 0, mux_sel is 0 and res_valid is 0.
- R2: With lead_cycles equal to 0, every mux_sel change after the first conversion happens on the same clock edge on which conv_n falls, and conv_n then stays low until the read finishes.
- R3: With lead_cycles equal to L > 0, conv_n falls exactly L clocks after the clock edge on which mux_sel changed.
- R4: While conv_n is low, rdy_n sampled low at a clock edge makes cs_n fall on that same edge, and cs_n stays low until every bit of the word has been read.
- R5: Each read makes exactly 24 rising edges of sclk. sclk rests at 0 outside a read and is high only while cs_n is low.
- R6: Every high phase and every low phase of sclk during a read lasts exactly max(sclk_half, 2) clocks, and this includes the low phase before the first rise.
- R7: On each sclk fall the block samples sdo. The first sample becomes bit 23 (the MSB) of the raw word and the last one becomes bit 0.
- R8: When bipolar is 1, res_data is the 24-bit raw word with bit 23 copied into bits 31..24. When bipolar is 0, bits 31..24 are 0.
- R9: res_valid is high for exactly one clock, starting one clock after the last sclk fall. res_ch then holds the mux_sel value that was present when conv_n fell for that word.
- R10: Conversions step through channels 0, 1, …, ch_count−1 and then wrap to 0. When ch_count is 0 or 1, every conversion uses channel 0.
- R11: conv_n and cs_n go back to 1 on the same edge once the read is over. mux_sel changes only while conv_n was high in the cycle before.
- R12: If run is cleared during a read, that word is still delivered. After it conv_n stays high, mux_sel returns to 0 and no further conversion starts. Setting run again starts a new scan at channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 keeps the scan running; 0 stops it at the next word boundary |
| ch_count | input | CH_W | Number of channels in the scan list |
| lead_cycles | input | LEAD_W | Clocks between a select change and the convert fall |
| sclk_half | input | DIV_W | Half period of sclk in clocks (2 is the minimum used) |
| bipolar | input | 1 | 1 = sign-extend the result, 0 = zero-extend it |
| rdy_n | input | 1 | Converter ready, active low |
| sdo | input | 1 | Serial data from the converter |
| mux_sel | output | CH_W | Analog multiplexer channel select |
| conv_n | output | 1 | Convert request, active low |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock produced by this block |
| res_valid | output | 1 | One-cycle strobe for a finished word |
| res_ch | output | CH_W | Channel tag of the word |
| res_data | output | OUT_W | Extended conversion result |

## Verification
The embedded properties rely on three things about the inputs. rdy_n and sdo are already synchronous to clk. ch_count, lead_cycles, sclk_half and bipolar change only while the block is idle. rdy_n goes back high no later than the edge on which cs_n rises. The bench keeps to these rules. It changes the configuration only after a scan has stopped and conv_n has stayed high. Its converter model drives sdo just after each sclk rise and releases rdy_n when chip select rises. The sweep covers channel counts 0, 1, 3 and 5, both lead settings, a clamped and an unclamped sclk divider, and both coding modes. Each scan ends with run cleared in the middle of a read.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    // Phases of one scan step, in the order the step runs through them.
    typedef enum logic [2:0] {
        ST_IDLE,   // stopped; convert and chip select released
        ST_LEAD,   // select moved, waiting out the lead time
        ST_WAIT,   // convert low, waiting for ready
        ST_READ,   // chip select low, clocking the word out
        ST_DONE    // word delivered; pick the next channel
    } scan_state_e;

    // Lowest half period of sclk, in system clocks.
    localparam int unsigned SCLK_MIN_HALF = 2;

    // Index of the last channel in the list; an empty list acts as one channel.
    function automatic logic [15:0] last_index(input logic [15:0] count);
        return (count == 16'd0) ? 16'd0 : count - 16'd1;
    endfunction

endpackage

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int LEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CH_W-1:0]   ch_count,
    input  logic [LEAD_W-1:0] lead_cycles,
    input  logic              rdy_n,
    input  logic              rx_done,
    output logic              rx_start,
    output logic              word_cap,
    output logic [CH_W-1:0]   mux_sel,
    output logic              conv_n,
    output logic              cs_n
);

    scan_state_e       state_q;
    logic [CH_W-1:0]   ch_q;
    logic [CH_W-1:0]   ch_last;
    logic [CH_W-1:0]   ch_next;
    logic [LEAD_W-1:0] lead_q;
    logic              conv_q;
    logic              cs_q;
    logic              lead_zero;

    always_comb begin
        ch_last   = CH_W'(last_index(16'(ch_count)));
        ch_next   = (ch_q >= ch_last) ? '0 : ch_q + 1'b1;
        lead_zero = (lead_cycles == '0);
        rx_start  = (state_q == ST_WAIT) && !rdy_n;
        word_cap  = (state_q == ST_READ) && rx_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
            lead_q  <= '0;
            conv_q  <= 1'b1;
            cs_q    <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (run) begin
                        if (lead_zero) begin
                            conv_q  <= 1'b0;
                            state_q <= ST_WAIT;
                        end else begin
                            lead_q  <= lead_cycles - 1'b1;
                            state_q <= ST_LEAD;
                        end
                    end
                end
                ST_LEAD: begin
                    if (lead_q == '0) begin
                        conv_q  <= 1'b0;
                        state_q <= ST_WAIT;
                    end else begin
                        lead_q <= lead_q - 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (!rdy_n) begin
                        cs_q    <= 1'b0;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rx_done) begin
                        cs_q    <= 1'b1;
                        conv_q  <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (!run) begin
                        ch_q    <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        ch_q <= ch_next;
                        if (lead_zero) begin
                            conv_q  <= 1'b0;
                            state_q <= ST_WAIT;
                        end else begin
                            lead_q  <= lead_cycles - 1'b1;
                            state_q <= ST_LEAD;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mux_sel = ch_q;
    assign conv_n  = conv_q;
    assign cs_n    = cs_q;

    // R11: the select only moves while convert was released
    p_mux_moves_released_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_q) |-> $past(conv_q));

    // R4: chip select is only low inside an active conversion
    p_cs_inside_conv_r4: assert property (@(posedge clk) disable iff (rst)
        !cs_q |-> !conv_q);

    // R4: the reader reports completion only during a read
    p_done_only_reading_r4: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (state_q == ST_READ));

    // R12: once stopped, convert stays high and the select is back at 0
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (conv_q && cs_q && ch_q == '0));

endmodule

// File: rtl/adc_scan_rx.sv
module adc_scan_rx
    import adc_scan_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIV_W-1:0]  sclk_half,
    input  logic              sdo,
    output logic              sclk,
    output logic              done,
    output logic [WORD_W-1:0] word
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    logic              active_q;
    logic              sclk_q;
    logic              done_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  half_eff;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] shift_q;

    always_comb begin
        half_eff = (sclk_half < DIV_W'(SCLK_MIN_HALF)) ? DIV_W'(SCLK_MIN_HALF) : sclk_half;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            shift_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !active_q) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b0;
                div_q    <= half_eff - 1'b1;
                bit_q    <= '0;
            end else if (active_q) begin
                if (div_q != '0) begin
                    div_q <= div_q - 1'b1;
                end else begin
                    div_q <= half_eff - 1'b1;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q  <= 1'b0;
                        shift_q <= {shift_q[WORD_W-2:0], sdo};
                        if (bit_q == LAST_BIT) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign done = done_q;
    assign word = shift_q;

    // R5: bit index never passes the word length
    p_bit_index_r5: assert property (@(posedge clk) disable iff (rst)
        bit_q <= LAST_BIT);

    // R5: serial clock rests low between reads
    p_sclk_rests_low_r5: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !sclk_q);

    // R6: phase counter stays within the effective half period
    p_half_bound_r6: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (div_q < half_eff));

endmodule

// File: rtl/adc_scan_fmt.sv
module adc_scan_fmt #(
    parameter int CH_W   = 4,
    parameter int WORD_W = 24,
    parameter int OUT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              bipolar,
    input  logic [CH_W-1:0]   ch,
    input  logic [WORD_W-1:0] word,
    output logic              valid,
    output logic [CH_W-1:0]   tag,
    output logic [OUT_W-1:0]  data
);

    localparam int PAD_W = OUT_W - WORD_W;

    logic [OUT_W-1:0] ext;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                ext = bipolar ? {{PAD_W{word[WORD_W-1]}}, word} : {{PAD_W{1'b0}}, word};
            end
        end else begin : g_same
            always_comb begin
                ext = word;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag   <= '0;
            data  <= '0;
        end else begin
            valid <= cap;
            if (cap) begin
                tag  <= ch;
                data <= ext;
            end
        end
    end

    // R9: valid strobe is a single cycle
    p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R8: sign bits agree with the low word in either mode
    p_extension_r8: assert property (@(posedge clk) disable iff (rst)
        (valid && $stable(bipolar) && PAD_W > 0) |->
            (data[OUT_W-1] == (bipolar & data[WORD_W-1])));

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
    parameter int CH_W   = 4,
    parameter int LEAD_W = 8,
    parameter int DIV_W  = 8,
    parameter int WORD_W = 24,
    parameter int OUT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CH_W-1:0]   ch_count,
    input  logic [LEAD_W-1:0] lead_cycles,
    input  logic [DIV_W-1:0]  sclk_half,
    input  logic              bipolar,
    input  logic              rdy_n,
    input  logic              sdo,
    output logic [CH_W-1:0]   mux_sel,
    output logic              conv_n,
    output logic              cs_n,
    output logic              sclk,
    output logic              res_valid,
    output logic [CH_W-1:0]   res_ch,
    output logic [OUT_W-1:0]  res_data
);

    logic              rx_start;
    logic              rx_done;
    logic              word_cap;
    logic [WORD_W-1:0] rx_word;

    adc_scan_seq #(
        .CH_W  (CH_W),
        .LEAD_W(LEAD_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .ch_count   (ch_count),
        .lead_cycles(lead_cycles),
        .rdy_n      (rdy_n),
        .rx_done    (rx_done),
        .rx_start   (rx_start),
        .word_cap   (word_cap),
        .mux_sel    (mux_sel),
        .conv_n     (conv_n),
        .cs_n       (cs_n)
    );

    adc_scan_rx #(
        .WORD_W(WORD_W),
        .DIV_W (DIV_W)
    ) rx_i (
        .clk      (clk),
        .rst      (rst),
        .start    (rx_start),
        .sclk_half(sclk_half),
        .sdo      (sdo),
        .sclk     (sclk),
        .done     (rx_done),
        .word     (rx_word)
    );

    adc_scan_fmt #(
        .CH_W  (CH_W),
        .WORD_W(WORD_W),
        .OUT_W (OUT_W)
    ) fmt_i (
        .clk    (clk),
        .rst    (rst),
        .cap    (word_cap),
        .bipolar(bipolar),
        .ch     (mux_sel),
        .word   (rx_word),
        .valid  (res_valid),
        .tag    (res_ch),
        .data   (res_data)
    );

    // R5: serial clock is high only with chip select asserted
    p_sclk_needs_cs_r5: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R11: chip select and convert are released together
    p_release_together_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> $rose(conv_n));

    // R9: a result appears just as the read is closed
    p_result_at_close_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> res_valid);

endmodule

// File: tb/adc_scan_ctrl_tb.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb_top;

    localparam int CH_W = 4, LEAD_W = 8, DIV_W = 8, WORD_W = 24, OUT_W = 32;
    localparam int LAT = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run = 1'b0;
    logic [CH_W-1:0]   ch_count = '0;
    logic [LEAD_W-1:0] lead_cycles = '0;
    logic [DIV_W-1:0]  sclk_half = '0;
    logic              bipolar = 1'b0;
    logic              rdy_n = 1'b1;
    logic              sdo = 1'b0;
    logic [CH_W-1:0]   mux_sel;
    logic              conv_n, cs_n, sclk, res_valid;
    logic [CH_W-1:0]   res_ch;
    logic [OUT_W-1:0]  res_data;

    int nvec = 0, nbad = 0;
    int cyc = 0;
    int wr = 0, rd = 0, nconv = 0;
    int exp_next = 0;
    int cnt_eff = 1, half_eff = 2;
    logic [CH_W-1:0]   exp_ch [0:255];
    logic [WORD_W-1:0] exp_w  [0:255];
    logic [WORD_W-1:0] cur_word = '0;
    int bitk = 0;
    int rdy_cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_scan_ctrl #(.CH_W(CH_W), .LEAD_W(LEAD_W), .DIV_W(DIV_W),
                    .WORD_W(WORD_W), .OUT_W(OUT_W)) dut_i (
        .clk(clk), .rst(rst), .run(run), .ch_count(ch_count),
        .lead_cycles(lead_cycles), .sclk_half(sclk_half), .bipolar(bipolar),
        .rdy_n(rdy_n), .sdo(sdo), .mux_sel(mux_sel), .conv_n(conv_n),
        .cs_n(cs_n), .sclk(sclk), .res_valid(res_valid), .res_ch(res_ch),
        .res_data(res_data));

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [WORD_W-1:0] pattern(input int ch, input int n);
        logic [31:0] v;
        v = (32'(ch) * 32'h0001_3579) ^ (32'(n) * 32'h000A_5A5B) ^ ((n % 2 == 1) ? 32'h0080_0000 : 32'h0);
        return v[WORD_W-1:0];
    endfunction

    function automatic logic [OUT_W-1:0] widen(input logic [WORD_W-1:0] w, input logic bip);
        return bip ? {{(OUT_W-WORD_W){w[WORD_W-1]}}, w} : {{(OUT_W-WORD_W){1'b0}}, w};
    endfunction

    // Converter model: record the channel at the convert fall, signal ready after LAT clocks
    initial begin
        forever begin
            @(negedge conv_n);
            if (!rst) begin
                // R10: channel order
                check(mux_sel == CH_W'(exp_next), "R10 channel order", mux_sel, exp_next);
                exp_next = (exp_next + 1) % cnt_eff;
                cur_word = pattern(int'(mux_sel), nconv);
                exp_ch[wr % 256] = mux_sel;
                exp_w[wr % 256]  = cur_word;
                wr++;
                nconv++;
                repeat (LAT) @(posedge clk);
                #1 rdy_n = 1'b0;
                rdy_cyc = cyc;
            end
        end
    end
    always @(negedge cs_n) bitk = 0;
    always @(posedge sclk) begin
        sdo = (bitk < WORD_W) ? cur_word[WORD_W-1-bitk] : 1'b0;
        bitk++;
    end
    always @(posedge cs_n) rdy_n = 1'b1;

    // Monitors, sampled on the falling clock edge
    logic [CH_W-1:0] prev_mux = '0;
    logic prev_conv = 1'b1, prev_cs = 1'b1, prev_sclk = 1'b0, armed = 1'b0;
    int since = 0, run_len = 0, rises = 0;

    always @(negedge clk) begin
        if (!rst) begin
            // R2/R3/R11: select changes versus convert fall
            if (mux_sel != prev_mux) begin
                check(prev_conv == 1'b1, "R11 select moved while convert low", prev_conv, 1);
                since = 0;
                armed = 1'b1;
            end else begin
                since++;
            end
            if (prev_conv && !conv_n && armed) begin
                if (lead_cycles == 0) check(since == 0, "R2 same-edge switch", since, 0);
                else check(since == int'(lead_cycles), "R3 lead time", since, lead_cycles);
                armed = 1'b0;
            end
            // R4: chip select follows ready by one edge
            if (prev_cs && !cs_n) begin
                check(cyc == rdy_cyc + 1, "R4 cs after ready", cyc, rdy_cyc + 1);
                run_len = 1;
                rises = 0;
            end else if (sclk != prev_sclk) begin
                check(run_len == half_eff, "R6 sclk phase length", run_len, half_eff);
                if (sclk) rises++;
                run_len = 1;
            end else begin
                run_len++;
            end
            // R11: convert released together with chip select; R5: rise count
            if (!prev_cs && cs_n) begin
                check(rises == WORD_W, "R5 sclk rises per read", rises, WORD_W);
                check(conv_n == 1'b1, "R11 convert released", conv_n, 1);
            end
            // R7/R8/R9: result contents
            if (res_valid) begin
                check(res_ch == exp_ch[rd % 256], "R9 channel tag", res_ch, exp_ch[rd % 256]);
                check(res_data == widen(exp_w[rd % 256], bipolar), "R7 R8 result word",
                      res_data, widen(exp_w[rd % 256], bipolar));
                check(!prev_cs && cs_n, "R9 valid timing", cs_n, 1);
                rd++;
            end
        end
        prev_mux  = mux_sel;
        prev_conv = conv_n;
        prev_cs   = cs_n;
        prev_sclk = sclk;
    end

    // Watchdog
    initial begin
        repeat (180000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int counts [4] = '{0, 1, 3, 5};
        int leads  [2] = '{0, 4};
        int halves [2] = '{0, 3};
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check(conv_n && cs_n && !sclk && mux_sel == 0 && !res_valid, "R1 reset state",
              {conv_n, cs_n, sclk, res_valid}, 4'b1100);
        #1 rst = 1'b0;
        @(negedge clk);
        check(conv_n && cs_n && !sclk && mux_sel == 0 && !res_valid, "R1 after release",
              {conv_n, cs_n, sclk, res_valid}, 4'b1100);
        for (int ci = 0; ci < 4; ci++) begin
            for (int li = 0; li < 2; li++) begin
                for (int hi = 0; hi < 2; hi++) begin
                    for (int bi = 0; bi < 2; bi++) begin
                        int n0, want;
                        ch_count    = CH_W'(counts[ci]);
                        lead_cycles = LEAD_W'(leads[li]);
                        sclk_half   = DIV_W'(halves[hi]);
                        bipolar     = bi[0];
                        cnt_eff     = (counts[ci] == 0) ? 1 : counts[ci];
                        half_eff    = (halves[hi] < 2) ? 2 : halves[hi];
                        exp_next    = 0;
                        armed       = 1'b0;
                        n0   = rd;
                        want = cnt_eff + 2;
                        @(negedge clk);
                        run = 1'b1;
                        while (!(rd == n0 + want - 1 && !cs_n)) @(negedge clk);
                        run = 1'b0;   // R12: stop in the middle of a read
                        while (rd != n0 + want) @(negedge clk);
                        repeat (120) begin
                            @(negedge clk);
                            if (!conv_n || res_valid) break;
                        end
                        check(rd == n0 + want, "R12 word count after stop", rd - n0, want);
                        check(conv_n == 1'b1 && mux_sel == 0, "R12 idle after stop",
                              {conv_n, mux_sel}, {1'b1, 4'h0});
                        check(wr == rd, "R12 conversions match results", wr, rd);
                    end
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule